// File: doc/BRIEF.md
# Central Hazard Scoreboard for Out-of-Order Issue

This controller sits beside a set of fixed-latency functional units and a small register file. It keeps all dependency state for the units in one place. Decoded instructions arrive one at a time in program order. Each instruction names a unit, an operation code, a destination register and two source registers. The controller decides when the instruction may enter its unit. It then tells the unit when it may fetch its operands, and later when it may drive its result into the register file. The datapath, forwarding, branches and memory are outside the block.

Each unit has one status slot. The slot holds the operation, the destination, both source numbers, the unit expected to produce each source, and a ready flag per source. A per-register table records which unit will next write each register. An instruction enters its unit only when that unit is idle and its destination has no pending writer. A stall holds the instruction at the input, and no later instruction can pass it. Operands are fetched once both ready flags are set, so units may start in a different order from program order. A finished unit keeps its result while some other unit still has to read the old contents of the destination register.

Top module: `scb_ctrl`

## Requirements
- R1: An instruction whose unit already holds an instruction that has not written back is stalled: `issue_stall_o`=1 and `issue_o`=0 in that cycle.
- R2: An instruction whose destination is still owed by any in-flight instruction is stalled. Once that write-back has happened, the same instruction is accepted.
- R3: A valid instruction that meets neither stall condition is accepted in the same cycle: `issue_o`=1 and `issue_stall_o`=0. At most one instruction is accepted per cycle.
- R4: If neither source of an accepted instruction has a pending producer, `go_read_o[unit]` is 1 in the cycle after acceptance. A unit is granted its operand read exactly once per instruction.
- R5: If a source has a pending producer, the read is held until that producer writes back. `go_read_o` rises in the cycle after the producer's `go_write_o`.
- R6: After its read, a unit waits for its `done_i` pulse. Its `go_write_o` can rise no earlier than the next cycle.
- R7: A finished unit whose destination equals a still-ready, unread source of another waiting unit is refused write-back. It is granted write-back in the cycle after that unit's `go_read_o`.
- R8: Only one unit writes back per cycle. When several are eligible, the lowest unit index wins and the others follow in later cycles.
- R9: `rf_wr_en_o` has exactly the destination bit set during a write-back and is zero otherwise. `rf_rd_en_o` has the bits of the source registers of every unit holding `go_read_o`.
- R10: A source whose producer writes back in the same cycle the consumer is accepted counts as ready. The consumer's `go_read_o` follows in the next cycle.
- R11: `fu_op_o` field u (bits u*OP_W upward) holds the operation code of the instruction accepted into unit u.
- R12: During and after reset, with no instruction presented, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | A decoded instruction is presented |
| instr_unit_i | input | $clog2(NUM_FU) | Target functional unit index |
| instr_op_i | input | OP_W | Operation code carried to the unit |
| instr_dst_i | input | $clog2(NUM_REG) | Destination register |
| instr_src_a_i | input | $clog2(NUM_REG) | First source register |
| instr_src_b_i | input | $clog2(NUM_REG) | Second source register |
| issue_o | output | 1 | Instruction accepted this cycle |
| issue_stall_o | output | 1 | Presented instruction is held |
| go_read_o | output | NUM_FU | Per unit: fetch operands now |
| done_i | input | NUM_FU | Per unit: execution finished (pulse) |
| go_write_o | output | NUM_FU | Per unit: write result now |
| rf_rd_en_o | output | NUM_REG | Register file read enables |
| rf_wr_en_o | output | NUM_REG | Register file write enables |
| fu_op_o | output | NUM_FU*OP_W | Held operation per unit |

## Verification
Two functions can fall in the same cycle. One is a write-back and a new acceptance whose source is the register being written. The other is two units becoming eligible for write-back together. The bench provokes the first by presenting the consumer while the producer's `go_write_o` is high. It then requires `go_read_o` for the consumer in the very next cycle instead of an endless wait. For the second, it pulses `done_i` for two units at once and expects their grants in index order on consecutive cycles. It also checks a write held back by a pending reader and released exactly one cycle after that reader's grant.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT_RD,
    PH_EXEC,
    PH_WAIT_WB
  } phase_e;
endpackage

// File: rtl/scb_unit_slot.sv
module scb_unit_slot
  import scb_pkg::*;
#(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  parameter int OP_W    = 4,
  parameter int IDX     = 0,
  localparam int REG_W  = $clog2(NUM_REG),
  localparam int TAG_W  = $clog2(NUM_FU)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic             pend_a_i,
  input  logic [TAG_W-1:0] tag_a_i,
  input  logic             pend_b_i,
  input  logic [TAG_W-1:0] tag_b_i,
  input  logic             done_i,
  input  logic             wr_vld_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             busy_o,
  output logic             wait_rd_o,
  output logic             wait_wb_o,
  output logic             go_read_o,
  output logic [OP_W-1:0]  op_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] src_a_o,
  output logic [REG_W-1:0] src_b_o,
  output logic             rdy_a_o,
  output logic             rdy_b_o
);
  phase_e           phase_q;
  logic [TAG_W-1:0] qa_q, qb_q;

  assign busy_o    = (phase_q != PH_IDLE);
  assign wait_rd_o = (phase_q == PH_WAIT_RD);
  assign wait_wb_o = (phase_q == PH_WAIT_WB);
  assign go_read_o = wait_rd_o && rdy_a_o && rdy_b_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      op_o    <= '0;
      dst_o   <= '0;
      src_a_o <= '0;
      src_b_o <= '0;
      qa_q    <= '0;
      qb_q    <= '0;
      rdy_a_o <= 1'b0;
      rdy_b_o <= 1'b0;
    end else if (issue_i) begin
      phase_q <= PH_WAIT_RD;
      op_o    <= op_i;
      dst_o   <= dst_i;
      src_a_o <= src_a_i;
      src_b_o <= src_b_i;
      qa_q    <= tag_a_i;
      qb_q    <= tag_b_i;
      rdy_a_o <= !pend_a_i;
      rdy_b_o <= !pend_b_i;
    end else begin
      unique case (phase_q)
        PH_WAIT_RD: begin
          if (go_read_o) begin
            phase_q <= PH_EXEC;
            // cleared so the write-after-read check no longer sees this unit
            rdy_a_o <= 1'b0;
            rdy_b_o <= 1'b0;
          end else begin
            if (wr_vld_i && !rdy_a_o && qa_q == wr_tag_i) rdy_a_o <= 1'b1;
            if (wr_vld_i && !rdy_b_o && qb_q == wr_tag_i) rdy_b_o <= 1'b1;
          end
        end
        PH_EXEC:    if (done_i) phase_q <= PH_WAIT_WB;
        PH_WAIT_WB: if (wr_vld_i && wr_tag_i == TAG_W'(IDX)) phase_q <= PH_IDLE;
        default:    phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scb_result_table.sv
module scb_result_table #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int REG_W  = $clog2(NUM_REG),
  localparam int TAG_W  = $clog2(NUM_FU)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] clr_reg_i,
  input  logic [REG_W-1:0] rd_a_i,
  input  logic [REG_W-1:0] rd_b_i,
  input  logic [REG_W-1:0] rd_dst_i,
  output logic             pend_a_o,
  output logic [TAG_W-1:0] tag_a_o,
  output logic             pend_b_o,
  output logic [TAG_W-1:0] tag_b_o,
  output logic             pend_dst_o
);
  logic [NUM_REG-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [NUM_REG];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[r] <= 1'b0;
        tag_q[r] <= '0;
      end else if (set_i && set_reg_i == REG_W'(r)) begin
        vld_q[r] <= 1'b1;
        tag_q[r] <= set_tag_i;
      end else if (clr_i && clr_reg_i == REG_W'(r)) begin
        vld_q[r] <= 1'b0;
      end
    end
  end

  assign pend_a_o   = vld_q[rd_a_i];
  assign tag_a_o    = tag_q[rd_a_i];
  assign pend_b_o   = vld_q[rd_b_i];
  assign tag_b_o    = tag_q[rd_b_i];
  assign pend_dst_o = vld_q[rd_dst_i];
endmodule

// File: rtl/scb_wb_arbiter.sv
module scb_wb_arbiter #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int REG_W  = $clog2(NUM_REG),
  localparam int TAG_W  = $clog2(NUM_FU)
) (
  input  logic [NUM_FU-1:0] wait_wb_i,
  input  logic [NUM_FU-1:0] wait_rd_i,
  input  logic [NUM_FU-1:0] rdy_a_i,
  input  logic [NUM_FU-1:0] rdy_b_i,
  input  logic [REG_W-1:0]  dst_i   [NUM_FU],
  input  logic [REG_W-1:0]  src_a_i [NUM_FU],
  input  logic [REG_W-1:0]  src_b_i [NUM_FU],
  output logic [NUM_FU-1:0] grant_o,
  output logic              wr_vld_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [REG_W-1:0]  wr_reg_o
);
  logic [NUM_FU-1:0] war_hold, req;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_war
    always_comb begin
      war_hold[u] = 1'b0;
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u && wait_rd_i[v] &&
            ((rdy_a_i[v] && src_a_i[v] == dst_i[u]) ||
             (rdy_b_i[v] && src_b_i[v] == dst_i[u])))
          war_hold[u] = 1'b1;
      end
    end
    assign req[u] = wait_wb_i[u] && !war_hold[u];
  end

  always_comb begin
    grant_o  = '0;
    wr_vld_o = 1'b0;
    wr_tag_o = '0;
    wr_reg_o = '0;
    for (int u = NUM_FU - 1; u >= 0; u--) begin
      if (req[u]) begin
        grant_o  = NUM_FU'(1) << u;
        wr_vld_o = 1'b1;
        wr_tag_o = TAG_W'(u);
        wr_reg_o = dst_i[u];
      end
    end
  end
endmodule

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  parameter int OP_W    = 4,
  localparam int REG_W  = $clog2(NUM_REG),
  localparam int TAG_W  = $clog2(NUM_FU)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   instr_valid_i,
  input  logic [TAG_W-1:0]       instr_unit_i,
  input  logic [OP_W-1:0]        instr_op_i,
  input  logic [REG_W-1:0]       instr_dst_i,
  input  logic [REG_W-1:0]       instr_src_a_i,
  input  logic [REG_W-1:0]       instr_src_b_i,
  output logic                   issue_o,
  output logic                   issue_stall_o,
  output logic [NUM_FU-1:0]      go_read_o,
  input  logic [NUM_FU-1:0]      done_i,
  output logic [NUM_FU-1:0]      go_write_o,
  output logic [NUM_REG-1:0]     rf_rd_en_o,
  output logic [NUM_REG-1:0]     rf_wr_en_o,
  output logic [NUM_FU*OP_W-1:0] fu_op_o
);
  logic [NUM_FU-1:0] busy, wait_rd, wait_wb, rdy_a, rdy_b;
  logic [REG_W-1:0]  u_dst [NUM_FU];
  logic [REG_W-1:0]  u_sa  [NUM_FU];
  logic [REG_W-1:0]  u_sb  [NUM_FU];
  logic              pend_a, pend_b, pend_dst;
  logic [TAG_W-1:0]  tag_a, tag_b;
  logic              wr_vld;
  logic [TAG_W-1:0]  wr_tag;
  logic [REG_W-1:0]  wr_reg;
  logic              eff_pend_a, eff_pend_b;

  assign issue_stall_o = instr_valid_i && (busy[instr_unit_i] || pend_dst);
  assign issue_o       = instr_valid_i && !issue_stall_o;

  // a producer writing back this very cycle no longer owes the value
  assign eff_pend_a = pend_a && !(wr_vld && wr_reg == instr_src_a_i);
  assign eff_pend_b = pend_b && !(wr_vld && wr_reg == instr_src_b_i);

  scb_result_table #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (issue_o),
    .set_reg_i  (instr_dst_i),
    .set_tag_i  (instr_unit_i),
    .clr_i      (wr_vld),
    .clr_reg_i  (wr_reg),
    .rd_a_i     (instr_src_a_i),
    .rd_b_i     (instr_src_b_i),
    .rd_dst_i   (instr_dst_i),
    .pend_a_o   (pend_a),
    .tag_a_o    (tag_a),
    .pend_b_o   (pend_b),
    .tag_b_o    (tag_b),
    .pend_dst_o (pend_dst)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
    scb_unit_slot #(
      .NUM_FU(NUM_FU), .NUM_REG(NUM_REG), .OP_W(OP_W), .IDX(u)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .issue_i   (issue_o && instr_unit_i == TAG_W'(u)),
      .op_i      (instr_op_i),
      .dst_i     (instr_dst_i),
      .src_a_i   (instr_src_a_i),
      .src_b_i   (instr_src_b_i),
      .pend_a_i  (eff_pend_a),
      .tag_a_i   (tag_a),
      .pend_b_i  (eff_pend_b),
      .tag_b_i   (tag_b),
      .done_i    (done_i[u]),
      .wr_vld_i  (wr_vld),
      .wr_tag_i  (wr_tag),
      .busy_o    (busy[u]),
      .wait_rd_o (wait_rd[u]),
      .wait_wb_o (wait_wb[u]),
      .go_read_o (go_read_o[u]),
      .op_o      (fu_op_o[u*OP_W +: OP_W]),
      .dst_o     (u_dst[u]),
      .src_a_o   (u_sa[u]),
      .src_b_o   (u_sb[u]),
      .rdy_a_o   (rdy_a[u]),
      .rdy_b_o   (rdy_b[u])
    );
  end

  scb_wb_arbiter #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_arb (
    .wait_wb_i (wait_wb),
    .wait_rd_i (wait_rd),
    .rdy_a_i   (rdy_a),
    .rdy_b_i   (rdy_b),
    .dst_i     (u_dst),
    .src_a_i   (u_sa),
    .src_b_i   (u_sb),
    .grant_o   (go_write_o),
    .wr_vld_o  (wr_vld),
    .wr_tag_o  (wr_tag),
    .wr_reg_o  (wr_reg)
  );

  always_comb begin
    rf_rd_en_o = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (go_read_o[u]) begin
        rf_rd_en_o[u_sa[u]] = 1'b1;
        rf_rd_en_o[u_sb[u]] = 1'b1;
      end
    end
  end

  assign rf_wr_en_o = wr_vld ? (NUM_REG'(1) << wr_reg) : '0;
endmodule

// File: rtl/scb_ctrl_chk.sv
module scb_ctrl_chk #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int TAG_W  = $clog2(NUM_FU)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               issue_o,
  input logic [TAG_W-1:0]   instr_unit_i,
  input logic [NUM_FU-1:0]  go_read_o,
  input logic [NUM_FU-1:0]  go_write_o,
  input logic [NUM_REG-1:0] rf_wr_en_o
);
  logic [NUM_FU-1:0] owned_q, read_q;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_track
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        owned_q[u] <= 1'b0;
        read_q[u]  <= 1'b0;
      end else if (go_write_o[u]) begin
        owned_q[u] <= 1'b0;
        read_q[u]  <= 1'b0;
      end else begin
        if (issue_o && instr_unit_i == TAG_W'(u)) owned_q[u] <= 1'b1;
        if (go_read_o[u]) read_q[u] <= 1'b1;
      end
    end

    AST_NO_ISSUE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_o && instr_unit_i == TAG_W'(u)) |-> !owned_q[u]); // R1

    AST_READ_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_read_o[u] |-> (owned_q[u] && !read_q[u])); // R4

    AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_write_o[u] |-> read_q[u]); // R6
  end

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(go_write_o)); // R8

  AST_WR_EN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rf_wr_en_o) == $countones(go_write_o)); // R9
endmodule

bind scb_ctrl scb_ctrl_chk #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_o      (issue_o),
  .instr_unit_i (instr_unit_i),
  .go_read_o    (go_read_o),
  .go_write_o   (go_write_o),
  .rf_wr_en_o   (rf_wr_en_o)
);

// File: tb/scb_ctrl_bench.sv
module scb_ctrl_bench;
  localparam int NUM_FU = 4, NUM_REG = 8, OP_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic instr_valid_i = 1'b0;
  logic [1:0] instr_unit_i = '0;
  logic [3:0] instr_op_i = '0;
  logic [2:0] instr_dst_i = '0, instr_src_a_i = '0, instr_src_b_i = '0;
  logic [3:0] done_i = '0;
  logic issue_o, issue_stall_o;
  logic [3:0] go_read_o, go_write_o;
  logic [7:0] rf_rd_en_o, rf_wr_en_o;
  logic [15:0] fu_op_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  scb_ctrl #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG), .OP_W(OP_W)) u_scb_ctrl (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic present(int u, int op, int d, int a, int b);
    instr_valid_i = 1'b1;
    instr_unit_i  = 2'(u);
    instr_op_i    = 4'(op);
    instr_dst_i   = 3'(d);
    instr_src_a_i = 3'(a);
    instr_src_b_i = 3'(b);
  endtask

  task automatic idle();
    instr_valid_i = 1'b0;
  endtask

  task automatic pulse_done(int mask);
    done_i = 4'(mask);
    tick();
    done_i = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R12 stall in reset", int'(issue_stall_o), 0);
    chk("R12 go_read in reset", int'(go_read_o), 0);
    chk("R12 go_write in reset", int'(go_write_o), 0);
    chk("R12 rf enables in reset", int'({rf_rd_en_o, rf_wr_en_o}), 0);
    chk("R12 ops in reset", int'(fu_op_o), 0);
  endtask

  // divide, dependent add, subtract overwriting the add's second source
  task automatic t_war();
    present(3, 9, 0, 2, 4); #1;
    chk("R3 div accepted", int'(issue_o), 1);
    tick();
    present(1, 2, 6, 0, 5); #1;
    chk("R4 div reads", int'(go_read_o), 4'b1000);
    chk("R9 div read enables", int'(rf_rd_en_o), 8'b0001_0100);
    chk("R11 div op held", int'(fu_op_o[15:12]), 9);
    chk("R3 add accepted", int'(issue_o), 1);
    tick();
    present(0, 3, 5, 5, 7); #1;
    chk("R5 add waits on div", int'(go_read_o), 0);
    chk("R3 sub accepted", int'(issue_o), 1);
    tick();
    idle(); #1;
    chk("R4 sub reads", int'(go_read_o), 4'b0001);
    tick();
    pulse_done(4'b0001); #1;
    chk("R7 sub write held", int'(go_write_o), 0);
    for (int i = 0; i < 3; i++) begin
      tick(); #1;
      chk("R7 sub still held", int'(go_write_o), 0);
    end
    pulse_done(4'b1000); #1;
    chk("R6 div writes", int'(go_write_o), 4'b1000);
    chk("R9 div write enable", int'(rf_wr_en_o), 8'b0000_0001);
    tick(); #1;
    chk("R5 add reads after div", int'(go_read_o), 4'b0010);
    chk("R7 sub held while add reads", int'(go_write_o), 0);
    tick(); #1;
    chk("R7 sub released", int'(go_write_o), 4'b0001);
    chk("R9 sub write enable", int'(rf_wr_en_o), 8'b0010_0000);
    tick();
    pulse_done(4'b0010); #1;
    chk("R6 add writes", int'(go_write_o), 4'b0010);
    tick(); #1;
    chk("R6 all quiet", int'(go_write_o), 0);
  endtask

  task automatic t_stalls();
    present(2, 5, 1, 2, 3); #1;
    chk("R3 mul accepted", int'(issue_o), 1);
    tick();
    present(1, 2, 1, 4, 5); #1;
    chk("R2 waw stall", int'(issue_stall_o), 1);
    chk("R2 waw no issue", int'(issue_o), 0);
    tick();
    present(2, 5, 7, 4, 5); #1;
    chk("R1 busy unit stall", int'(issue_stall_o), 1);
    chk("R1 busy unit no issue", int'(issue_o), 0);
    idle();
    pulse_done(4'b0100);
    // consumer of F1 presented in the write-back cycle of its producer
    present(0, 1, 4, 1, 2); #1;
    chk("R10 mul writes", int'(go_write_o), 4'b0100);
    chk("R10 consumer accepted", int'(issue_o), 1);
    tick();
    idle(); #1;
    chk("R10 consumer reads next cycle", int'(go_read_o), 4'b0001);
    chk("R9 consumer read enables", int'(rf_rd_en_o), 8'b0000_0110);
    tick();
    pulse_done(4'b0001); #1;
    chk("R6 consumer writes", int'(go_write_o), 4'b0001);
    tick();
    present(1, 2, 1, 4, 5); #1;
    chk("R2 accepted after write", int'(issue_o), 1);
    tick();
    idle(); #1;
    chk("R4 add reads", int'(go_read_o), 4'b0010);
    tick();
    pulse_done(4'b0010); tick();
  endtask

  task automatic t_priority();
    present(0, 6, 2, 0, 0); #1;
    chk("R3 int accepted", int'(issue_o), 1);
    tick();
    present(1, 7, 3, 0, 0); #1;
    chk("R4 int reads", int'(go_read_o), 4'b0001);
    tick();
    idle(); #1;
    chk("R4 add reads", int'(go_read_o), 4'b0010);
    chk("R11 add op held", int'(fu_op_o[7:4]), 7);
    tick();
    pulse_done(4'b0011); #1;
    chk("R8 lowest index first", int'(go_write_o), 4'b0001);
    tick(); #1;
    chk("R8 second follows", int'(go_write_o), 4'b0010);
    tick(); #1;
    chk("R8 no more writes", int'(go_write_o), 0);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_war();
    t_stalls();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule